// File: doc/BRIEF.md
# I2S Microphone Capture Master

This block is the clock master on a two-wire audio link to a slave digital microphone. It divides the system clock into a bit clock and derives a word select at one sixty-fourth of the bit clock. Word select toggles on falling bit-clock edges, so each frame holds two 32-clock channel slots. The microphone sends serial data that the block samples on rising bit-clock edges.

In each slot the microphone sends a 24-bit two's-complement word, MSB first, one bit clock after the word-select transition. Only the upper 18 bits of that word carry the sample. The block keeps those 18 bits and drops the six zero bits and the undriven tail of the slot. It sign-extends the sample to 32 bits and presents it on a valid/ready output together with a channel flag.

After enable, framing starts at the first falling edge of word select, so the first sample delivered is a complete left sample. If a sample completes while the previous one is still waiting, the newer sample replaces the older one and a sticky overrun flag is raised.

Top module: `i2s_mic_capture`

## Requirements
- R1: The bit-clock period is div_i system clocks with equal high and low times (div_i even, at least 2). div_i is captured only while en_i is low, so a change while enabled leaves the period unchanged.
- R2: Word select is low for 32 bit clocks and high for 32 bit clocks, and changes only together with a falling bit-clock edge. While disabled, bit clock is low and word select is high.
- R3: Counting rising bit-clock edges after a word-select transition as 1, 2, 3 and so on, edges 2 to 19 carry the kept sample, MSB first. All other bit periods of the slot, including the six zero bits and the trailing bits, have no effect on data_o.
- R4: data_o is the 18-bit sample sign-extended to 32 bits: bits 31:18 equal bit 17.
- R5: right_o is 0 for a sample taken while word select was low (left) and 1 for one taken while word select was high (right).
- R6: After each enable, the partial slot before the first falling edge of word select is discarded, and the first sample delivered has right_o = 0.
- R7: valid_o stays high, and the output holds, until a cycle with ready_i high. valid_o falls after that cycle if no new sample arrives.
- R8: A sample that completes while valid_o is high and ready_i is low replaces the held sample and sets overrun_o. overrun_o stays set until a cycle with ovr_clr_i high, and a new overrun in the same cycle takes priority over the clear.
- R9: While rst_ni is low: valid_o, overrun_o and bclk_o are 0, and ws_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low stops the clocks and loads the divider |
| div_i | input | DIV_W | Bit-clock period in system clocks, even |
| bclk_o | output | 1 | Bit clock to the microphone |
| ws_o | output | 1 | Word select to the microphone, low = left |
| sd_i | input | 1 | Serial data from the microphone |
| valid_o | output | 1 | Sample available |
| ready_i | input | 1 | Consumer accepts the sample |
| data_o | output | OUT_W | Sign-extended sample |
| right_o | output | 1 | Channel of the sample, 1 = right |
| overrun_o | output | 1 | Sticky flag: a sample was overwritten before it was accepted |
| ovr_clr_i | input | 1 | Clears overrun_o |

## Verification
The checks assume that div_i is even and at least 2, and that sd_i changes only after a falling bit-clock edge so it is settled before the next rising edge. They also assume that ready_i and ovr_clr_i are synchronous to the system clock. The bench keeps within these limits by using only the dividers 2, 4 and 6. Its microphone model drives sd_i one nanosecond after each falling edge of bclk_o. It changes ready_i, ovr_clr_i, en_i and div_i one nanosecond after a rising system-clock edge. The undriven tail bits are modelled as alternating values, so that any bit read from outside the kept window corrupts the expected sample.

// File: rtl/i2s_cap_pkg.sv
package i2s_cap_pkg;
  localparam int unsigned FRAME_LEN = 64;
  localparam int unsigned SLOT_LEN  = FRAME_LEN / 2;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN);
  localparam int unsigned POS_W     = CNT_W - 1;

  typedef struct packed {
    logic rise;
    logic fall;
  } bclk_evt_t;
endpackage

// File: rtl/i2s_cap_clkgen.sv
module i2s_cap_clkgen
  import i2s_cap_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bclk_o,
  output bclk_evt_t        evt_o
);
  logic [DIV_W-1:0] div_q, cnt_q, half;
  logic             bclk_q, term;

  always_comb begin
    half = div_q >> 1;
    if (half == '0) half = DIV_W'(1);
    term = (cnt_q == half - DIV_W'(1));
  end

  assign evt_o.rise = en_i & term & ~bclk_q;
  assign evt_o.fall = en_i & term & bclk_q;
  assign bclk_o     = bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= DIV_W'(2);
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (!en_i) begin
      div_q  <= div_i;
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (term) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/i2s_cap_framer.sv
module i2s_cap_framer
  import i2s_cap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  bclk_evt_t        evt_i,
  output logic             ws_o,
  output logic [POS_W-1:0] pos_o,
  output logic             armed_o
);
  // counter idles mid-frame so ws rests high; first wrap to 0 opens a left slot
  localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(SLOT_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= CNT_IDLE;
      armed_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= CNT_IDLE;
      armed_q <= 1'b0;
    end else if (evt_i.fall) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == '1) armed_q <= 1'b1;
    end
  end

  assign ws_o    = cnt_q[CNT_W-1];
  assign pos_o   = cnt_q[POS_W-1:0];
  assign armed_o = armed_q;
endmodule

// File: rtl/i2s_cap_shift.sv
module i2s_cap_shift
  import i2s_cap_pkg::*;
#(
  parameter int unsigned KEEP_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rise_i,
  input  logic              sd_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              armed_i,
  output logic              done_o,
  output logic [KEEP_W-1:0] smp_o
);
  localparam logic [POS_W-1:0] POS_FIRST = POS_W'(1);
  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(KEEP_W);

  logic [KEEP_W-2:0] sh_q;
  logic              in_win;

  assign in_win = (pos_i >= POS_FIRST) && (pos_i < POS_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sh_q <= '0;
    else if (!en_i)             sh_q <= '0;
    else if (rise_i && in_win)  sh_q <= {sh_q[KEEP_W-3:0], sd_i};
  end

  // last kept bit is taken straight from the pin on the final edge
  assign done_o = rise_i & armed_i & (pos_i == POS_LAST);
  assign smp_o  = {sh_q, sd_i};
endmodule

// File: rtl/i2s_mic_capture.sv
module i2s_mic_capture
  import i2s_cap_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned KEEP_W = 18,
  parameter int unsigned OUT_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bclk_o,
  output logic             ws_o,
  input  logic             sd_i,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [OUT_W-1:0] data_o,
  output logic             right_o,
  output logic             overrun_o,
  input  logic             ovr_clr_i
);
  localparam int unsigned EXT_W = OUT_W - KEEP_W;

  bclk_evt_t         evt;
  logic [POS_W-1:0]  pos;
  logic              armed, done;
  logic [KEEP_W-1:0] smp;
  logic              valid_q, right_q, ovr_q;
  logic [OUT_W-1:0]  data_q;

  i2s_cap_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk_i, .rst_ni, .en_i, .div_i,
    .bclk_o, .evt_o(evt)
  );

  i2s_cap_framer u_frm (
    .clk_i, .rst_ni, .en_i, .evt_i(evt),
    .ws_o, .pos_o(pos), .armed_o(armed)
  );

  i2s_cap_shift #(.KEEP_W(KEEP_W)) u_sh (
    .clk_i, .rst_ni, .en_i, .rise_i(evt.rise), .sd_i,
    .pos_i(pos), .armed_i(armed), .done_o(done), .smp_o(smp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      right_q <= 1'b0;
      data_q  <= '0;
    end else if (done) begin
      valid_q <= 1'b1;
      right_q <= ws_o;
      data_q  <= {{EXT_W{smp[KEEP_W-1]}}, smp};
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ovr_q <= 1'b0;
    else if (done && valid_q && !ready_i)  ovr_q <= 1'b1;
    else if (ovr_clr_i)                    ovr_q <= 1'b0;
  end

  assign valid_o   = valid_q;
  assign right_o   = right_q;
  assign data_o    = data_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/i2s_mic_capture_chk.sv
module i2s_mic_capture_chk #(
  parameter int unsigned KEEP_W = 18,
  parameter int unsigned OUT_W  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             bclk_o,
  input logic             ws_o,
  input logic             valid_o,
  input logic             ready_i,
  input logic [OUT_W-1:0] data_o,
  input logic             overrun_o,
  input logic             ovr_clr_i
);
  localparam int unsigned TOP_N = OUT_W - KEEP_W + 1;

  AST_BCLK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !bclk_o); // R2

  AST_WS_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && (ws_o != $past(ws_o))) |-> $fell(bclk_o)); // R2

  AST_SIGN_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (($countones(data_o[OUT_W-1:KEEP_W-1]) == 0) ||
                 ($countones(data_o[OUT_W-1:KEEP_W-1]) == TOP_N))); // R4

  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> valid_o); // R7

  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !ovr_clr_i) |=> overrun_o); // R8

  AST_OVR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(valid_o && !ready_i)); // R8
endmodule

bind i2s_mic_capture i2s_mic_capture_chk #(.KEEP_W(KEEP_W), .OUT_W(OUT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .bclk_o(bclk_o), .ws_o(ws_o),
  .valid_o(valid_o), .ready_i(ready_i), .data_o(data_o),
  .overrun_o(overrun_o), .ovr_clr_i(ovr_clr_i)
);

// File: tb/sim_i2s_mic_capture.sv
`timescale 1ns/1ps
module sim_i2s_mic_capture;
  localparam int DIV_W = 8;
  localparam int TCLK  = 4;

  logic clk = 1'b0, rst_ni = 1'b0, en = 1'b0, sd = 1'b0, ready = 1'b1, clr = 1'b0;
  logic [DIV_W-1:0] div = 8'd4;
  logic bclk, ws, valid, right, ovr;
  logic [31:0] data;

  always #(TCLK/2) clk = ~clk;

  i2s_mic_capture u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .div_i(div),
    .bclk_o(bclk), .ws_o(ws), .sd_i(sd),
    .valid_o(valid), .ready_i(ready), .data_o(data), .right_o(right),
    .overrun_o(ovr), .ovr_clr_i(clr)
  );

  int errors = 0, checks = 0, rx = 0;
  bit mon_en = 1'b0, first_pending = 1'b0;
  logic [18:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] sext(input logic [17:0] v);
    return {{14{v[17]}}, v};
  endfunction

  function automatic logic [17:0] gen(input int n);
    case (n % 40)
      0: return 18'h1FFFF;  1: return 18'h20000;
      2: return 18'h00000;  3: return 18'h3FFFF;
      4: return 18'h15555;  5: return 18'h2AAAA;
      6: return 18'h00001;  7: return 18'h20001;
      default: return 18'((n * 32'h2345 + 32'h1A5) & 32'h3FFFF);
    endcase
  endfunction

  // microphone model: drives on falling bclk, MSB one clock after ws change
  logic ws_prev = 1'b1;
  int k = 0, slot_n = 0;
  bit mic_armed = 1'b0;
  logic [17:0] cur = '0;
  always @(negedge bclk) begin
    #1;
    if (ws != ws_prev) begin
      ws_prev = ws; k = 0;
      if (!ws) mic_armed = 1'b1;
      cur = gen(slot_n); slot_n++;
    end else k++;
    if (k >= 1 && k <= 18)      sd = cur[18-k];
    else if (k >= 19 && k <= 24) sd = 1'b0;
    else                         sd = 1'(k[0] ^ slot_n[0] ^ 1);
    if (k == 18 && mic_armed) exp_q.push_back({ws, cur});
  end

  task automatic mic_reset();
    ws_prev = 1'b1; k = 0; mic_armed = 1'b0;
  endtask

  always @(negedge clk) begin
    if (mon_en && valid && ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected sample", data, 32'h0);
      else begin
        logic [18:0] e;
        e = exp_q.pop_front();
        chk(data == sext(e[17:0]), "R3/R4 data", data, sext(e[17:0]));
        chk(right == e[18], "R5 channel", 32'(right), 32'(e[18]));
        if (first_pending) begin
          chk(right == 1'b0, "R6 first left", 32'(right), 32'h0);
          first_pending = 1'b0;
        end
      end
      rx++;
    end
  end

  task automatic wait_rx(input int n);
    int tgt;
    tgt = rx + n;
    while (rx < tgt) @(posedge clk);
    #1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    realtime t0, t1;
    repeat (3) tick();
    chk(valid == 0, "R9 valid", 32'(valid), 0);
    chk(ovr == 0, "R9 overrun", 32'(ovr), 0);
    chk(bclk == 0, "R9 bclk", 32'(bclk), 0);
    chk(ws == 1, "R9 ws", 32'(ws), 1);
    rst_ni = 1'b1;
    tick();

    for (int d = 2; d <= 6; d += 2) begin
      div = 8'(d);
      tick();
      first_pending = 1'b1; mon_en = 1'b1; en = 1'b1;
      @(posedge bclk); t0 = $realtime;
      @(negedge bclk); t1 = $realtime;
      chk(int'(t1 - t0) == d * TCLK / 2, "R1 high time", 32'(int'(t1 - t0)), 32'(d * TCLK / 2));
      @(posedge bclk);
      chk(int'($realtime - t0) == d * TCLK, "R1 period", 32'(int'($realtime - t0)), 32'(d * TCLK));
      #1 div = 8'(d + 2);
      @(posedge bclk); t0 = $realtime;
      @(posedge bclk);
      chk(int'($realtime - t0) == d * TCLK, "R1 div ignored while enabled",
          32'(int'($realtime - t0)), 32'(d * TCLK));
      @(negedge ws); t0 = $realtime;
      @(posedge ws); t1 = $realtime;
      chk(int'(t1 - t0) == 32 * d * TCLK, "R2 ws low", 32'(int'(t1 - t0)), 32'(32 * d * TCLK));
      @(negedge ws);
      chk(int'($realtime - t0) == 64 * d * TCLK, "R2 ws frame",
          32'(int'($realtime - t0)), 32'(64 * d * TCLK));
      wait_rx(12);
      en = 1'b0;
      chk(exp_q.size() == 0, "R3 no pending sample", 32'(exp_q.size()), 0);
      repeat (4) tick();
      chk(bclk == 0 && ws == 1, "R2 idle", {30'b0, bclk, ws}, 32'h1);
      mic_reset(); exp_q.delete();
    end

    // overrun: hold ready low across several samples
    div = 8'd2; tick();
    first_pending = 1'b1; en = 1'b1;
    wait_rx(2);
    mon_en = 1'b0; ready = 1'b0;
    repeat (200) tick();
    begin
      logic r0;
      r0 = right;
      while (right == r0) @(posedge clk);
      #1;
    end
    chk(valid == 1, "R7 valid held", 32'(valid), 1);
    chk(ovr == 1, "R8 overrun set", 32'(ovr), 1);
    chk(data == sext(exp_q[$][17:0]), "R8 newest kept", data, sext(exp_q[$][17:0]));
    chk(right == exp_q[$][18], "R8 newest channel", 32'(right), 32'(exp_q[$][18]));
    repeat (5) tick();
    chk(ovr == 1, "R8 sticky", 32'(ovr), 1);
    clr = 1'b1; tick(); clr = 1'b0;
    chk(ovr == 0, "R8 cleared", 32'(ovr), 0);
    ready = 1'b1; tick();
    chk(valid == 0, "R7 valid drops", 32'(valid), 0);
    exp_q.delete(); mon_en = 1'b1;
    wait_rx(4);
    chk(ovr == 0, "R8 stays clear", 32'(ovr), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule